// File: doc/BRIEF.md
# Fault-Tolerant Phase Error Combiner

This block sits between the three single-phase angle detectors of a three-phase phase-locked loop and its PI regulator. Each line-to-line channel supplies a signed phase-angle error sample, and a separate sag detector supplies one flag per channel. On every sample strobe the block refers all three errors to the first channel by adding fixed one-third-turn offsets. It classifies the flags into one of eight fault modes and produces one combined error. That error is an average over the healthy channels only, the sole survivor's error, or zero when nothing is usable.

Angles are signed two's-complement fractions of a full turn, so the offsets wrap on overflow without extra logic. The block also keeps a two-bit index of the channel the loop should use as its synchronising reference. That index freezes on the last healthy choice while every channel is sagged, so the downstream loop coasts at its present frequency on a known reference.

Top module: `phase_err_combiner`

## Requirements
- R1: The aligned errors are c1 = err_ab, c2 = err_bc + OFS and c3 = err_ca − OFS, all taken modulo 2^W as signed W-bit values, where OFS = round(2^W/3) (21845 for W = 16).
- R2: sag_flags bit 0 marks channel 1, bit 1 channel 2 and bit 2 channel 3 (1 = sagged). mode_code is 0 when no bit is set. It is 1, 2 or 3 when only channel 3, 2 or 1 is sagged. It is 4, 5 or 6 when only channel 1, 2 or 3 remains healthy, and 7 when all three are sagged.
- R3: In mode 0, err_out is the integer nearest to (c1 + c2 + c3)/3.
- R4: In modes 1 to 3, err_out is floor((x + y + 1)/2), where x and y are the aligned errors of the two healthy channels.
- R5: In modes 4 to 6, err_out equals the aligned error of the one healthy channel, unchanged.
- R6: In mode 7, err_out is zero.
- R7: ref_chan (0 = channel 1, 1 = channel 2, 2 = channel 3) becomes the lowest-numbered healthy channel on each result. In mode 7 it keeps its previous value.
- R8: A strobe sampled at clock edge k gives out_valid high for exactly one cycle after edge k+1 together with the new results. Without a strobe, all result outputs hold their values.
- R9: After reset, out_valid, err_out, mode_code and ref_chan are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe; captures the inputs |
| err_ab | input | W | Channel 1 angle error, signed fraction of a turn |
| err_bc | input | W | Channel 2 angle error before alignment |
| err_ca | input | W | Channel 3 angle error before alignment |
| sag_flags | input | 3 | Per-channel sag indication |
| out_valid | output | 1 | One-cycle pulse marking new results |
| err_out | output | W | Combined error for the regulator |
| mode_code | output | 3 | Fault mode 0 to 7 |
| ref_chan | output | 2 | Synchronising reference channel index |

## Verification
The bench drives raw errors near the signed limits, so the one-third-turn offsets must wrap. A design that saturated them, or that swapped the signs of the two offsets, returns a combined error far from the expected value. It places three-way sums whose remainder is two, with both signs, against the nearest-integer rule, and pair sums of odd parity against half-up rounding; a truncating divider is off by one there. It steps the flags through sequences such as one channel sagged, then all, then a different set, to show that the reference index freezes in the all-sagged mode and moves to the lowest healthy channel otherwise. It also leaves gaps between strobes, so an output that does not hold between results shows up as a changed value.

// File: rtl/phc_pkg.sv
package phc_pkg;

    localparam int unsigned NCH = 3;

    typedef enum logic [2:0] {
        FM_NONE    = 3'd0,
        FM_LOSE_C3 = 3'd1,
        FM_LOSE_C2 = 3'd2,
        FM_LOSE_C1 = 3'd3,
        FM_ONLY_C1 = 3'd4,
        FM_ONLY_C2 = 3'd5,
        FM_ONLY_C3 = 3'd6,
        FM_ALL     = 3'd7
    } fault_mode_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EVAL = 1'b1
    } seq_state_e;

    // Flag bit i set means channel i+1 is sagged.
    function automatic fault_mode_e classify(input logic [NCH-1:0] sag);
        fault_mode_e m;
        unique case (sag)
            3'b000:  m = FM_NONE;
            3'b100:  m = FM_LOSE_C3;
            3'b010:  m = FM_LOSE_C2;
            3'b001:  m = FM_LOSE_C1;
            3'b110:  m = FM_ONLY_C1;
            3'b101:  m = FM_ONLY_C2;
            3'b011:  m = FM_ONLY_C3;
            default: m = FM_ALL;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/phc_align.sv
module phc_align #(
    parameter int W = 16
) (
    input  logic signed [W-1:0] raw     [phc_pkg::NCH],
    output logic signed [W-1:0] aligned [phc_pkg::NCH]
);
    // One third of a full turn, rounded: (2^(W+1) + 3) / 6.
    localparam longint THIRD_L = ((longint'(1) << (W + 1)) + 3) / 6;
    localparam logic signed [W-1:0] THIRD = W'(THIRD_L);

    for (genvar g = 0; g < int'(phc_pkg::NCH); g++) begin : g_ch
        if (g == 0) begin : g_base
            assign aligned[g] = raw[g];
        end else if (g == 1) begin : g_lead
            assign aligned[g] = raw[g] + THIRD;
        end else begin : g_lag
            assign aligned[g] = raw[g] - THIRD;
        end
    end
endmodule

// File: rtl/phc_mode_dec.sv
module phc_mode_dec
    import phc_pkg::*;
(
    input  logic [NCH-1:0] sag,
    output fault_mode_e    mode,
    output logic [1:0]     pref,
    output logic           any_ok
);
    always_comb begin
        mode   = classify(sag);
        any_ok = ~&sag;
        pref   = 2'd0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (!sag[i]) pref = 2'(i);
        end
    end
endmodule

// File: rtl/phc_blend.sv
module phc_blend
    import phc_pkg::*;
#(
    parameter int W = 16,
    parameter int K = W + 4
) (
    input  logic signed [W-1:0] c [NCH],
    input  fault_mode_e         mode,
    output logic signed [W-1:0] err
);
    localparam int SW = W + 2;
    localparam int PW = SW + K + 1;
    // Reciprocal of three scaled by 2^K, rounded.
    localparam longint RECIP_L = ((longint'(1) << (K + 1)) + 3) / 6;
    localparam logic signed [PW-1:0] RECIP = PW'(RECIP_L);
    localparam logic signed [PW-1:0] HALF  = PW'(longint'(1) << (K - 1));

    logic signed [SW-1:0] sum3;
    logic signed [PW-1:0] sum_x, prod, biased, shifted;
    logic signed [W-1:0]  mean3;
    logic signed [W:0]    p12, p13, p23;
    logic signed [W-1:0]  m12, m13, m23;

    always_comb begin
        sum3    = SW'(c[0]) + SW'(c[1]) + SW'(c[2]);
        sum_x   = {{(PW - SW){sum3[SW-1]}}, sum3};
        prod    = sum_x * RECIP;
        biased  = prod + HALF;
        shifted = biased >>> K;
        mean3   = shifted[W-1:0];
    end

    always_comb begin
        p12 = (W+1)'(c[0]) + (W+1)'(c[1]) + (W+1)'(1);
        p13 = (W+1)'(c[0]) + (W+1)'(c[2]) + (W+1)'(1);
        p23 = (W+1)'(c[1]) + (W+1)'(c[2]) + (W+1)'(1);
        m12 = p12[W:1];
        m13 = p13[W:1];
        m23 = p23[W:1];
    end

    always_comb begin
        unique case (mode)
            FM_NONE:    err = mean3;
            FM_LOSE_C3: err = m12;
            FM_LOSE_C2: err = m13;
            FM_LOSE_C1: err = m23;
            FM_ONLY_C1: err = c[0];
            FM_ONLY_C2: err = c[1];
            FM_ONLY_C3: err = c[2];
            default:    err = '0;
        endcase
    end
endmodule

// File: rtl/phase_err_combiner.sv
module phase_err_combiner
    import phc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic signed [W-1:0] err_ab,
    input  logic signed [W-1:0] err_bc,
    input  logic signed [W-1:0] err_ca,
    input  logic [2:0]          sag_flags,
    output logic                out_valid,
    output logic signed [W-1:0] err_out,
    output logic [2:0]          mode_code,
    output logic [1:0]          ref_chan
);
    seq_state_e          state_q, state_d;
    logic signed [W-1:0] raw_q   [NCH];
    logic signed [W-1:0] aligned [NCH];
    logic [NCH-1:0]      sag_q;
    fault_mode_e         mode_w;
    logic [1:0]          pref_w;
    logic                any_ok_w;
    logic signed [W-1:0] blend_w;

    // Sample capture on the strobe.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) raw_q[i] <= '0;
            sag_q <= '0;
        end else if (in_valid) begin
            raw_q[0] <= err_ab;
            raw_q[1] <= err_bc;
            raw_q[2] <= err_ca;
            sag_q    <= sag_flags;
        end
    end

    phc_align #(.W(W)) u_align (
        .raw     (raw_q),
        .aligned (aligned)
    );

    phc_mode_dec u_mode (
        .sag    (sag_q),
        .mode   (mode_w),
        .pref   (pref_w),
        .any_ok (any_ok_w)
    );

    phc_blend #(.W(W)) u_blend (
        .c    (aligned),
        .mode (mode_w),
        .err  (blend_w)
    );

    // Sequencer: IDLE -> EVAL on strobe; EVAL -> EVAL on strobe, else IDLE.
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EVAL : ST_IDLE;
            ST_EVAL: state_d = in_valid ? ST_EVAL : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Result registers, written only while evaluating.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            err_out   <= '0;
            mode_code <= '0;
            ref_chan  <= '0;
        end else begin
            out_valid <= (state_q == ST_EVAL);
            if (state_q == ST_EVAL) begin
                err_out   <= blend_w;
                mode_code <= mode_w;
                if (any_ok_w) ref_chan <= pref_w;
            end
        end
    end
endmodule

// File: rtl/phase_err_combiner_chk.sv
module phase_err_combiner_chk #(
    parameter int W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                out_valid,
    input logic signed [W-1:0] err_out,
    input logic [2:0]          mode_code,
    input logic [1:0]          ref_chan
);
    a_r8_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    a_r8_valid_origin: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

    a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(err_out) && $stable(mode_code) && $stable(ref_chan)));

    a_r6_zero_all_sag: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && mode_code == 3'd7) |-> (err_out == '0));

    a_r7_ref_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && mode_code == 3'd7) |-> $stable(ref_chan));

    a_r7_ref_range: assert property (@(posedge clk) disable iff (!rst_n)
        ref_chan != 2'd3);
endmodule

bind phase_err_combiner phase_err_combiner_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .err_out   (err_out),
    .mode_code (mode_code),
    .ref_chan  (ref_chan)
);

// File: tb/phase_err_combiner_tb.sv
module phase_err_combiner_tb;
    localparam int W    = 16;
    localparam int FULL = 1 << W;
    localparam int OFS  = (FULL + 1) / 3;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic signed [W-1:0] err_ab = '0, err_bc = '0, err_ca = '0;
    logic [2:0]          sag_flags = '0;
    logic                out_valid;
    logic signed [W-1:0] err_out;
    logic [2:0]          mode_code;
    logic [1:0]          ref_chan;

    int n_chk = 0;
    int n_bad = 0;
    int ref_model = 0;

    always #5 clk = ~clk;

    phase_err_combiner #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .err_ab(err_ab), .err_bc(err_bc), .err_ca(err_ca),
        .sag_flags(sag_flags), .out_valid(out_valid), .err_out(err_out),
        .mode_code(mode_code), .ref_chan(ref_chan)
    );

    function automatic int wrapw(input int v);
        int r = v % FULL;
        if (r < 0) r += FULL;
        if (r >= FULL / 2) r -= FULL;
        return r;
    endfunction

    function automatic int exp_mode(input logic [2:0] s);
        case (s)
            3'b000: return 0;
            3'b100: return 1;
            3'b010: return 2;
            3'b001: return 3;
            3'b110: return 4;
            3'b101: return 5;
            3'b011: return 6;
            default: return 7;
        endcase
    endfunction

    function automatic int near3(input int s);
        int q = (s - (((s % 3) + 3) % 3)) / 3;
        if (s - 3 * q == 2) q += 1;
        return q;
    endfunction

    function automatic int half_up(input int s);
        int t = s + 1;
        return (t - (((t % 2) + 2) % 2)) / 2;
    endfunction

    function automatic int exp_err(input int a, input int b, input int c, input logic [2:0] s);
        int c1 = wrapw(a);
        int c2 = wrapw(b + OFS);
        int c3 = wrapw(c - OFS);
        case (exp_mode(s))
            0: return near3(c1 + c2 + c3);
            1: return half_up(c1 + c2);
            2: return half_up(c1 + c3);
            3: return half_up(c2 + c3);
            4: return c1;
            5: return c2;
            6: return c3;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply(input int a, input int b, input int c, input logic [2:0] s);
        int e  = exp_err(a, b, c, s);
        int m  = exp_mode(s);
        int held;
        if (s != 3'b111) ref_model = (!s[0]) ? 0 : ((!s[1]) ? 1 : 2);
        @(negedge clk);
        err_ab = a[W-1:0]; err_bc = b[W-1:0]; err_ca = c[W-1:0];
        sag_flags = s; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R8 pulse early", int'(out_valid), 0);
        @(negedge clk);
        check("R8 pulse", int'(out_valid), 1);
        check(m == 0 ? "R3 mean3" : m < 4 ? "R4 mean2" : m < 7 ? "R5 single" : "R6 zero",
              int'(err_out), e);
        check("R2 mode", int'(mode_code), m);
        check("R7 ref", int'(ref_chan), ref_model);
        held = int'(err_out);
        @(negedge clk);
        check("R8 one cycle", int'(out_valid), 0);
        check("R8 hold", int'(err_out), held);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 valid", int'(out_valid), 0);
        check("R9 err", int'(err_out), 0);
        check("R9 mode", int'(mode_code), 0);
        check("R9 ref", int'(ref_chan), 0);

        // R1 wrap of both offsets, single survivors.
        apply(0, 20000, 0, 3'b101);
        apply(0, 0, -20000, 3'b011);
        apply(-32768, 0, 0, 3'b110);
        // R2 every mode once
        for (int k = 0; k < 8; k++) apply(100, 50 - OFS, -30 + OFS, 3'(k));
        // R3 rounding, remainder two, both signs
        apply(1, 1 - OFS, 0 + OFS, 3'b000);
        apply(-1, -1 - OFS, 0 + OFS, 3'b000);
        apply(32767, 32767 - OFS, 32767 + OFS, 3'b000);
        // R4 half-up rounding
        apply(-3, 0 - OFS, 999, 3'b100);
        apply(-1, 5, 0 + OFS, 3'b010);
        // R7 freeze and move
        apply(10, 20, 30, 3'b001);
        apply(10, 20, 30, 3'b111);
        apply(10, 20, 30, 3'b011);
        apply(10, 20, 30, 3'b111);
        apply(10, 20, 30, 3'b000);

        // Random mix with small and full-range errors.
        for (int n = 0; n < 400; n++) begin
            int a, b, c;
            if (n % 2 == 0) begin
                a = int'($urandom_range(0, FULL - 1)) - FULL / 2;
                b = int'($urandom_range(0, FULL - 1)) - FULL / 2;
                c = int'($urandom_range(0, FULL - 1)) - FULL / 2;
            end else begin
                a = int'($urandom_range(0, 200)) - 100;
                b = int'($urandom_range(0, 200)) - 100 - OFS;
                c = int'($urandom_range(0, 200)) - 100 + OFS;
            end
            apply(a, b, c, 3'($urandom_range(0, 7)));
            if ($urandom_range(0, 3) == 0) repeat (2) @(negedge clk);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule